// File: doc/BRIEF.md
# Multiplexed-Bus Burst Target

This block is the responding side of a synchronous parallel bus on which address and data share one 32-bit path. An initiator opens a transaction by pulling the active-low start strobe low while the bus is idle. In that same cycle it places an address on the shared path and a 4-bit command on the four command/byte-enable lines. The target decodes the command and address in that cycle. If it owns the access, it claims the transaction with an active-low claim signal. It then spends one quiet turnaround cycle and moves one 32-bit word per cycle whenever both sides' ready signals are low. The address steps by four bytes per word. The initiator marks the final word by raising the start strobe during that word's data phase. After that word the target releases every signal.

Two spaces are served. The memory space is a small word store whose window base is assigned by software. The configuration space is reached only when the dedicated config-select input is high. Its word 0 returns a fixed identifier and its word 1 holds the writable window base. I/O-space commands are never claimed.

The state machine has four states:
- IDLE waits for an address phase. From there it takes the edge *claim* to TURN on a decode hit, or the edge *decline* to SKIP on a miss.
- TURN is the turnaround cycle. It always takes the edge *open* to DATA.
- DATA moves words. On each transfer it takes the edge *next* back to DATA, except when the start strobe is high, when it takes the edge *finish* to IDLE.
- SKIP ignores a foreign transaction. It stays in SKIP until both the start strobe and the initiator-ready signal are high, and then takes the edge *idle* to IDLE.

Top module: `mux_burst_target`

## Requirements
- R1: After reset, claim_n and slv_rdy_n are high and abus_oe is low. The window base counts as unassigned, so no memory command is claimed until config word 1 has been written.
- R2: An address phase is a rising edge at which bus_start_n is low and mst_rdy_n is high while the target is in IDLE. abus_in and cmd_be_n are captured at that edge. Each command code (on cmd_be_n) selects a space and a direction:

  | Code | Space | Direction |
  |------|-------|-----------|
  | 4'h2 | I/O | read |
  | 4'h3 | I/O | write |
  | 4'h6 | memory | read |
  | 4'h7 | memory | write |
  | 4'hA | configuration | read |
  | 4'hB | configuration | write |

- R3: On a claimed access, claim_n is low from the cycle after the address phase through the cycle of the final word, without a break.
- R4: The cycle after the address phase is a turnaround: slv_rdy_n is high and abus_oe is low. slv_rdy_n is low in every later cycle of the transaction.
- R5: A word moves only at an edge where both mst_rdy_n and slv_rdy_n are low. In a cycle where the initiator holds mst_rdy_n high, the data and byte enables it presents are not written, and the address does not advance.
- R6: Each moved word advances the address by 4 bytes. Within the memory window the word index wraps modulo the store depth (16 words by default).
- R7: A word moved while bus_start_n is high is the last one. In the next cycle claim_n and slv_rdy_n are high and abus_oe is low. This holds even when bus_start_n is already high during the turnaround, so a one-word burst still moves exactly one word.
- R8: On a write, bit i of cmd_be_n low enables byte lane i (abus_in bits 8i+7..8i). Bytes whose enable is high keep their old value.
- R9: A configuration command is claimed only when cfg_sel is high at the address phase. Address bits 10..2 index the configuration words: word 0 reads DEV_ID, word 1 reads the window base, and other words read 0.
- R10: Writing config word 1 sets the window base; the bits below the window size (bits 5..0 by default) always read 0. A memory command is claimed when address bits 31..6 equal the base bits 31..6.
- R11: An I/O command, a memory address outside the window, or a configuration command without cfg_sel leaves claim_n high, abus_oe low and the storage unchanged. The target ignores the bus until bus_start_n and mst_rdy_n are both high.
- R12: During a read data phase, abus_oe is high exactly while slv_rdy_n is low, and abus_out carries the word at the current address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_start_n | input | 1 | Transaction start/continue strobe, active low |
| mst_rdy_n | input | 1 | Initiator ready, active low |
| abus_in | input | 32 | Shared address/data path as seen by the target |
| cmd_be_n | input | 4 | Command in address phase, active-low byte enables afterwards |
| cfg_sel | input | 1 | Configuration select for this target |
| abus_out | output | 32 | Read data driven onto the shared path |
| abus_oe | output | 1 | Enable for abus_out onto the shared path |
| claim_n | output | 1 | Device claim, active low |
| slv_rdy_n | output | 1 | Target ready, active low |

## Verification
Two functions can meet in one cycle: the end-of-burst mark and a data transfer. In a one-word burst the end mark meets the turnaround instead. Bursts of length one raise bus_start_n from the turnaround cycle onward. Longer bursts raise it only on the word that moves, and random initiator wait states come before it. The bench judges each case by the number of words written to its model store, by the read data compared word by word, and by claim_n and slv_rdy_n going high in exactly the cycle after the last transfer.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TURN,
        ST_DATA,
        ST_SKIP
    } tgt_state_e;

    typedef enum logic [1:0] {
        SP_NONE,
        SP_MEM,
        SP_CFG
    } space_e;

    localparam logic [3:0] CMD_IO_RD  = 4'h2;
    localparam logic [3:0] CMD_IO_WR  = 4'h3;
    localparam logic [3:0] CMD_MEM_RD = 4'h6;
    localparam logic [3:0] CMD_MEM_WR = 4'h7;
    localparam logic [3:0] CMD_CFG_RD = 4'hA;
    localparam logic [3:0] CMD_CFG_WR = 4'hB;

endpackage

// File: rtl/mbt_decode.sv
module mbt_decode
    import mbt_pkg::*;
#(
    parameter int HI_W = 26
) (
    input  logic [3:0]      cmd,
    input  logic [HI_W-1:0] addr_hi,
    input  logic [HI_W-1:0] base_hi,
    input  logic            base_set,
    input  logic            cfg_sel,
    output space_e          hit
);

    always_comb begin
        hit = SP_NONE;
        case (cmd)
            CMD_MEM_RD, CMD_MEM_WR: begin
                if (base_set && (addr_hi == base_hi)) hit = SP_MEM;
            end
            CMD_CFG_RD, CMD_CFG_WR: begin
                if (cfg_sel) hit = SP_CFG;
            end
            default: hit = SP_NONE;
        endcase
    end

endmodule

// File: rtl/mbt_cfg.sv
module mbt_cfg #(
    parameter int          DW      = 32,
    parameter int          WIN_LSB = 6,
    parameter int          IDX_W   = 9,
    parameter logic [31:0] DEV_ID  = 32'h1D0C_5A01
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [IDX_W-1:0]      idx,
    input  logic [DW/8-1:0]       be_n,
    input  logic [DW-1:WIN_LSB]   wdata_hi,
    output logic [DW-1:0]         rdata,
    output logic [DW-1:WIN_LSB]   base_hi,
    output logic                  base_set
);

    logic [DW-1:WIN_LSB] merged_hi;

    always_comb begin
        for (int j = WIN_LSB; j < DW; j++) begin
            merged_hi[j] = be_n[j/8] ? base_hi[j] : wdata_hi[j];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_hi  <= '0;
            base_set <= 1'b0;
        end else if (we && (idx == IDX_W'(1))) begin
            base_hi  <= merged_hi;
            base_set <= 1'b1;
        end
    end

    always_comb begin
        if (idx == IDX_W'(0))      rdata = DEV_ID;
        else if (idx == IDX_W'(1)) rdata = {base_hi, {WIN_LSB{1'b0}}};
        else                       rdata = '0;
    end

endmodule

// File: rtl/mbt_mem.sv
module mbt_mem #(
    parameter int DW    = 32,
    parameter int WORDS = 16,
    localparam int AW   = $clog2(WORDS),
    localparam int NB   = DW/8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [NB-1:0] be_n,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] store [WORDS];
    logic [DW-1:0] lane_mask;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign lane_mask[b*8 +: 8] = {8{~be_n[b]}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) store[i] <= '0;
        end else if (we) begin
            store[idx] <= (store[idx] & ~lane_mask) | (wdata & lane_mask);
        end
    end

    assign rdata = store[idx];

endmodule

// File: rtl/mux_burst_target.sv
module mux_burst_target
    import mbt_pkg::*;
#(
    parameter int          DW        = 32,
    parameter int          MEM_WORDS = 16,
    parameter logic [31:0] DEV_ID    = 32'h1D0C_5A01
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_start_n,
    input  logic          mst_rdy_n,
    input  logic [DW-1:0] abus_in,
    input  logic [3:0]    cmd_be_n,
    input  logic          cfg_sel,
    output logic [DW-1:0] abus_out,
    output logic          abus_oe,
    output logic          claim_n,
    output logic          slv_rdy_n
);

    localparam int MEM_AW  = $clog2(MEM_WORDS);
    localparam int WIN_LSB = MEM_AW + 2;
    localparam int CFG_IW  = 9;
    localparam int HI_W    = DW - WIN_LSB;

    tgt_state_e state_q, state_d;
    space_e     space_q, hit;
    logic       wr_q;
    logic [DW-1:0] addr_q;

    logic addr_phase, xfer, last_xfer;
    logic [DW-1:WIN_LSB] base_hi;
    logic base_set;
    logic [DW-1:0] cfg_rdata, mem_rdata, rd_word;
    logic cfg_we, mem_we;

    assign addr_phase = (state_q == ST_IDLE) && !bus_start_n && mst_rdy_n;
    assign xfer       = (state_q == ST_DATA) && !mst_rdy_n;
    assign last_xfer  = xfer && bus_start_n;
    assign mem_we     = xfer && wr_q && (space_q == SP_MEM);
    assign cfg_we     = xfer && wr_q && (space_q == SP_CFG);

    mbt_decode #(.HI_W(HI_W)) u_decode (
        .cmd      (cmd_be_n),
        .addr_hi  (abus_in[DW-1:WIN_LSB]),
        .base_hi  (base_hi),
        .base_set (base_set),
        .cfg_sel  (cfg_sel),
        .hit      (hit)
    );

    mbt_cfg #(.DW(DW), .WIN_LSB(WIN_LSB), .IDX_W(CFG_IW), .DEV_ID(DEV_ID)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .idx      (addr_q[CFG_IW+1:2]),
        .be_n     (cmd_be_n),
        .wdata_hi (abus_in[DW-1:WIN_LSB]),
        .rdata    (cfg_rdata),
        .base_hi  (base_hi),
        .base_set (base_set)
    );

    mbt_mem #(.DW(DW), .WORDS(MEM_WORDS)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .idx   (addr_q[MEM_AW+1:2]),
        .be_n  (cmd_be_n),
        .wdata (abus_in),
        .rdata (mem_rdata)
    );

    assign rd_word = (space_q == SP_CFG) ? cfg_rdata : mem_rdata;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (addr_phase) state_d = (hit != SP_NONE) ? ST_TURN : ST_SKIP;
            ST_TURN: state_d = ST_DATA;
            ST_DATA: if (last_xfer) state_d = ST_IDLE;
            ST_SKIP: if (bus_start_n && mst_rdy_n) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // captured address-phase context and burst address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            space_q <= SP_NONE;
            wr_q    <= 1'b0;
        end else if (addr_phase) begin
            addr_q  <= abus_in;
            space_q <= hit;
            wr_q    <= cmd_be_n[0];
        end else if (xfer) begin
            addr_q  <= addr_q + DW'(4);
        end
    end

    // outputs decoded from the state
    always_comb begin
        claim_n   = 1'b1;
        slv_rdy_n = 1'b1;
        abus_oe   = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_SKIP: ;
            ST_TURN: claim_n = 1'b0;
            ST_DATA: begin
                claim_n   = 1'b0;
                slv_rdy_n = 1'b0;
                abus_oe   = !wr_q;
            end
        endcase
    end

    assign abus_out = abus_oe ? rd_word : '0;

    // R3: claim is held until the word moved with the start strobe high
    a_r3_claim_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!claim_n && !(bus_start_n && !mst_rdy_n && !slv_rdy_n)) |=> !claim_n);

    // R4: the first claimed cycle is quiet, the next one is ready
    a_r4_turn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(claim_n) |-> (slv_rdy_n && !abus_oe));

    a_r4_ready_after_turn: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(claim_n) |=> !slv_rdy_n);

    // R5: an initiator wait freezes the burst address
    a_r5_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!slv_rdy_n && mst_rdy_n) |=> $stable(addr_q));

    // R6: every moved word steps the address by one word
    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!slv_rdy_n && !mst_rdy_n) |=> (addr_q == $past(addr_q) + DW'(4)));

    // R7: everything is released after the final word
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!slv_rdy_n && !mst_rdy_n && bus_start_n) |=> (claim_n && slv_rdy_n && !abus_oe));

    // R12: the path is driven only inside a ready data phase of a claim
    a_r12_drive_claimed: assert property (@(posedge clk) disable iff (!rst_n)
        abus_oe |-> (!claim_n && !slv_rdy_n));

endmodule

// File: tb/mux_burst_target_tb.sv
`timescale 1ns/1ps
module mux_burst_target_tb;

    localparam logic [31:0] DEV_ID = 32'h1D0C_5A01;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_start_n = 1'b1;
    logic        mst_rdy_n = 1'b1;
    logic [31:0] abus_in = '0;
    logic [3:0]  cmd_be_n = 4'hF;
    logic        cfg_sel = 1'b0;
    logic [31:0] abus_out;
    logic        abus_oe, claim_n, slv_rdy_n;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [31:0] m_mem [16];
    logic [31:0] m_base = '0;
    bit          m_base_set = 0;
    logic [31:0] wd  [8];
    logic [3:0]  wbe [8];

    always #10 clk = ~clk;

    mux_burst_target u_dut (
        .clk(clk), .rst_n(rst_n), .bus_start_n(bus_start_n), .mst_rdy_n(mst_rdy_n),
        .abus_in(abus_in), .cmd_be_n(cmd_be_n), .cfg_sel(cfg_sel),
        .abus_out(abus_out), .abus_oe(abus_oe), .claim_n(claim_n), .slv_rdy_n(slv_rdy_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int exp_space(input logic [3:0] cmd, input logic [31:0] addr, input bit sel);
        if ((cmd == 4'h6 || cmd == 4'h7) && m_base_set && addr[31:6] == m_base[31:6]) return 1;
        if ((cmd == 4'hA || cmd == 4'hB) && sel) return 2;
        return 0;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] be_n);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (!be_n[b]) r[b*8 +: 8] = nw[b*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] exp_cfg(input int idx);
        if (idx == 0) return DEV_ID;
        if (idx == 1) return m_base;
        return 32'h0;
    endfunction

    // one initiator transaction; write data and enables come from wd/wbe
    task automatic burst(input logic [3:0] cmd, input logic [31:0] addr, input bit sel,
                         input int n, input int wait_pct);
        int sp = exp_space(cmd, addr, sel);
        bit wr = cmd[0];
        int k = 0;
        bit first = 1;
        bit hold;
        logic [31:0] wa = addr >> 2;
        @(negedge clk);
        bus_start_n = 0; mst_rdy_n = 1; abus_in = addr; cmd_be_n = cmd; cfg_sel = sel;
        @(posedge clk);
        if (sp == 0) begin
            for (int c = 0; c < 4; c++) begin
                @(negedge clk);
                chk("R11 claim_n on unclaimed access", {31'b0, claim_n}, 32'd1);
                chk("R11 abus_oe on unclaimed access", {31'b0, abus_oe}, 32'd0);
                mst_rdy_n = 0; bus_start_n = (c == 3); abus_in = $urandom; cmd_be_n = 4'h0;
                @(posedge clk);
            end
        end else begin
            while (k < n) begin
                @(negedge clk);
                chk("R3 claim_n during transaction", {31'b0, claim_n}, 32'd0);
                if (first) begin
                    chk("R4 slv_rdy_n in turnaround", {31'b0, slv_rdy_n}, 32'd1);
                    chk("R4 abus_oe in turnaround", {31'b0, abus_oe}, 32'd0);
                end else begin
                    chk("R4 slv_rdy_n after turnaround", {31'b0, slv_rdy_n}, 32'd0);
                end
                hold = (k == n-1) ? 1'b0 : (($urandom % 100) < wait_pct);
                mst_rdy_n = hold;
                bus_start_n = (k == n-1);
                if (!slv_rdy_n && !hold) begin
                    if (!wr) begin
                        chk("R12 abus_oe in read data phase", {31'b0, abus_oe}, 32'd1);
                        chk("R6 R12 read word", abus_out,
                            (sp == 1) ? m_mem[wa[3:0]] : exp_cfg(int'(wa[8:0])));
                    end else begin
                        abus_in = wd[k]; cmd_be_n = wbe[k];
                        if (sp == 1) m_mem[wa[3:0]] = merge(m_mem[wa[3:0]], wd[k], wbe[k]);
                        else if (wa[8:0] == 9'd1) begin
                            m_base = merge(m_base, wd[k], wbe[k]) & 32'hFFFF_FFC0;
                            m_base_set = 1;
                        end
                    end
                    k++;
                    wa++;
                end else begin
                    abus_in = $urandom; cmd_be_n = 4'h0;  // ignored: no transfer (R5)
                end
                first = 0;
                @(posedge clk);
            end
            @(negedge clk);
            chk("R7 claim_n after last word", {31'b0, claim_n}, 32'd1);
            chk("R7 slv_rdy_n after last word", {31'b0, slv_rdy_n}, 32'd1);
            chk("R7 abus_oe after last word", {31'b0, abus_oe}, 32'd0);
        end
        bus_start_n = 1; mst_rdy_n = 1; abus_in = '0; cmd_be_n = 4'hF; cfg_sel = 0;
        @(posedge clk);
    endtask

    task automatic fill_full(input int n);
        for (int i = 0; i < 8; i++) begin
            wd[i]  = (i < n) ? $urandom : 32'h0;
            wbe[i] = 4'h0;
        end
    endtask

    initial begin
        void'($urandom(32'd7301));
        for (int i = 0; i < 16; i++) m_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 claim_n in reset", {31'b0, claim_n}, 32'd1);
        chk("R1 slv_rdy_n in reset", {31'b0, slv_rdy_n}, 32'd1);
        chk("R1 abus_oe in reset", {31'b0, abus_oe}, 32'd0);
        rst_n = 1;
        @(negedge clk);

        // R1 R10: memory command before the base is assigned
        burst(4'h6, 32'h0000_0000, 0, 1, 0);
        // R9: config without select, then with select (ID and base words)
        burst(4'hA, 32'h0000_0000, 0, 1, 0);
        burst(4'hA, 32'h0000_0000, 1, 2, 0);
        // R10: assign base, low bits forced to zero, read back
        fill_full(1); wd[0] = 32'h8000_0077;
        burst(4'hB, 32'h0000_0004, 1, 1, 0);
        burst(4'hA, 32'h0000_0004, 1, 1, 0);
        chk("R10 base low bits", m_base, 32'h8000_0040);
        // R11: I/O command at the window
        burst(4'h2, m_base, 0, 2, 0);
        // R2 R6: fill the whole store, then read with initiator waits (R5)
        fill_full(8);
        burst(4'h7, m_base, 0, 8, 0);
        fill_full(8);
        burst(4'h7, m_base + 32, 0, 8, 40);
        burst(4'h6, m_base, 0, 8, 50);
        burst(4'h6, m_base + 32, 0, 8, 0);
        // R8: partial byte enables
        fill_full(4);
        wbe[0] = 4'hE; wbe[1] = 4'h5; wbe[2] = 4'hF; wbe[3] = 4'h7;
        burst(4'h7, m_base + 12, 0, 4, 0);
        burst(4'h6, m_base + 12, 0, 4, 0);
        // R11: write outside the window leaves the store unchanged
        fill_full(4);
        burst(4'h7, m_base + 32'h40, 0, 4, 0);
        burst(4'h6, m_base, 0, 4, 0);
        // R6: wrap at the end of the store, R7: single words with waits
        fill_full(4);
        burst(4'h7, m_base + 56, 0, 4, 0);
        burst(4'h6, m_base + 56, 0, 4, 30);
        burst(4'h6, m_base + 4, 0, 1, 0);
        // random mix
        for (int t = 0; t < 40; t++) begin
            int len = 1 + ($urandom % 6);
            int idx = $urandom % 16;
            bit w = $urandom % 2;
            for (int i = 0; i < 8; i++) begin wd[i] = $urandom; wbe[i] = 4'($urandom); end
            burst(w ? 4'h7 : 4'h6, m_base + 32'(idx * 4), 0, len, 30);
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule